// File: doc/BRIEF.md
# Rate-Smoothing Elastic Bit Buffer

This block takes a serial bit stream delivered on a gated strobe. The stream is bursty and has holes where overhead bits were taken out. The block parks the bits in a 16-entry circular store and sends them out again on an evenly spaced read strobe, which the block makes itself.

The read strobe comes from a numerically controlled oscillator clocked by the system clock. A phase accumulator adds a step on every cycle, and each carry out of the accumulator is one read. The step is a nominal value plus a correction proportional to the distance between the store's fill level and its midpoint of eight. The read pointer therefore trails the write pointer by about eight addresses. Bursts and gaps in the write strobe only nudge the read spacing and do not copy through to the output. A larger `GAIN` shift weakens the correction. That gives heavier smoothing but a narrower range of input rates the loop can follow.

The write strobe has two possible sources, chosen by `rate_sel`: every gated pulse, or one pulse in every `DIV_N` through a coarse divider. A three-state controller runs the block:
- `ST_PRIME` waits after reset until eight bits are stored. Transition `prime_done` leads to `ST_TRACK`.
- `ST_TRACK` reads under loop control. Transition `slip`, taken when the fill reaches 0 or 15, leads to `ST_SLIP`.
- `ST_SLIP` keeps reading and holds the error flag until reset.

Top module: `rate_smoother`

## Requirements
- R1: Each accepted write strobe stores the bit on `gate_bit` at the write address and advances that address by one, modulo 16. Bits leave in the order they were accepted.
- R2: After reset no read strobe appears until eight bits have been accepted. Within 20 cycles of the eighth accepted bit, reading has begun.
- R3: Each read outputs the next stored bit on `dout`. `tstrobe` is a single-cycle pulse in the same cycle that `dout` takes the new bit.
- R4: With the defaults and a write stream averaging one bit per 8 cycles, bits accepted minus bits read stays between 3 and 13 at every read.
- R5: With the defaults, while write spacing wanders between 4 and 12 cycles, the spacing between consecutive read strobes stays between 6 and 10 cycles.
- R6: `dout_n` is always the inverse of `dout`, and `tstrobe_n` is always the inverse of `tstrobe`.
- R7: With `rate_sel`=0 every `gate_pulse` is a write. With `rate_sel`=1 only pulses number DIV_N, 2·DIV_N, … after reset are writes (DIV_N=3 by default), and the bits on the other pulses are dropped.
- R8: After reading has begun, a fill level of 0 or 15 sets `slip_err`. The flag stays set until reset, even if later traffic is normal.
- R9: During and right after reset, `dout`=0, `tstrobe`=0, `dout_n`=1, `tstrobe_n`=1 and `slip_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_pulse | input | 1 | One-cycle gated input clock pulse |
| gate_bit | input | 1 | Data bit qualified by `gate_pulse` |
| rate_sel | input | 1 | 0: direct write strobe, 1: divide-by-DIV_N strobe |
| dout | output | 1 | Smoothed output bit |
| dout_n | output | 1 | Complement of `dout` |
| tstrobe | output | 1 | Output timing strobe (the read clock) |
| tstrobe_n | output | 1 | Complement of `tstrobe` |
| slip_err | output | 1 | Sticky fill-limit error |

## Verification
A wrong pointer or a wrong divider phase shows up at `dout`. The bit order goes wrong at the first read after priming, about eight read periods (roughly 70 cycles) after the wrong write. A wrong loop sign or gain shows up as read strobe spacing outside 6 to 10 cycles. It also shows up as accepted-minus-read drift, within a few tens of reads. A wrong controller state shows in three ways: early strobes during priming, `slip_err` failing to set or clearing, and reads that never start.

// File: rtl/rate_smoother_pkg.sv
package rate_smoother_pkg;
    typedef enum logic [1:0] {
        ST_PRIME = 2'd0,
        ST_TRACK = 2'd1,
        ST_SLIP  = 2'd2
    } smooth_state_t;
endpackage

// File: rtl/wr_strobe_sel.sv
module wr_strobe_sel #(
    parameter int DIV_N = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rate_sel,
    input  logic gate_pulse,
    output logic wr_stb
);
    localparam int CW = (DIV_N > 2) ? $clog2(DIV_N) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_N - 1);

    logic [CW-1:0] div_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (rate_sel && gate_pulse) begin
            div_cnt <= (div_cnt == LAST) ? '0 : div_cnt + 1'b1;
        end
    end

    always_comb begin
        wr_stb = rate_sel ? (gate_pulse && div_cnt == LAST) : gate_pulse;
    end

    // R7: a write strobe never appears without a gated pulse
    assert_strobe_from_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> gate_pulse);
endmodule

// File: rtl/elastic_store.sv
module elastic_store #(
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_bit,
    input  logic             rd_en,
    output logic             rd_bit,
    output logic [PTR_W-1:0] fill
);
    localparam int DEPTH = 2 ** PTR_W;

    logic [DEPTH-1:0] cells;
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] rptr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cells  <= '0;
            wptr   <= '0;
            rptr   <= '0;
            rd_bit <= 1'b0;
        end else begin
            if (wr_en) begin
                cells[wptr] <= wr_bit;
                wptr        <= wptr + 1'b1;
            end
            if (rd_en) begin
                rd_bit <= cells[rptr];
                rptr   <= rptr + 1'b1;
            end
        end
    end

    always_comb begin
        fill = wptr - rptr;
    end

    // R1: a lone write raises the fill level by exactly one
    assert_write_advances_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en) |=> fill == $past(fill) + 1'b1);
    // R3: output bit is held between reads
    assert_dout_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_bit));
endmodule

// File: rtl/smooth_nco.sv
module smooth_nco #(
    parameter int ACC_W    = 16,
    parameter int PTR_W    = 4,
    parameter int STEP_NOM = 8192,
    parameter int GAIN     = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PTR_W-1:0] fill,
    output logic             rd_tick
);
    localparam int SW       = ACC_W + 2;
    localparam int KP_SHIFT = ACC_W - 6;
    localparam int MID      = 2 ** (PTR_W - 1);

    logic signed [SW-1:0] err_s;
    logic signed [SW-1:0] step_s;
    logic [ACC_W-1:0]     acc;
    logic [ACC_W:0]       sum;

    always_comb begin
        err_s  = $signed({{(SW - PTR_W){1'b0}}, fill}) - $signed(SW'(MID));
        step_s = $signed(SW'(STEP_NOM)) + ((err_s <<< KP_SHIFT) >>> GAIN);
        sum    = {1'b0, acc} + {1'b0, step_s[ACC_W-1:0]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            acc     <= '0;
            rd_tick <= 1'b0;
        end else begin
            acc     <= sum[ACC_W-1:0];
            rd_tick <= sum[ACC_W];
        end
    end

    // R5: read ticks are never adjacent
    assert_tick_spaced_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_tick |=> !rd_tick);
endmodule

// File: rtl/rate_smoother.sv
module rate_smoother #(
    parameter int PTR_W    = 4,
    parameter int ACC_W    = 16,
    parameter int STEP_NOM = 8192,
    parameter int GAIN     = 1,
    parameter int DIV_N    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_pulse,
    input  logic gate_bit,
    input  logic rate_sel,
    output logic dout,
    output logic dout_n,
    output logic tstrobe,
    output logic tstrobe_n,
    output logic slip_err
);
    import rate_smoother_pkg::*;

    localparam logic [PTR_W-1:0] MID  = PTR_W'(2 ** (PTR_W - 1));
    localparam logic [PTR_W-1:0] FULL = PTR_W'(2 ** PTR_W - 1);

    smooth_state_t    state, state_nx;
    logic             wr_stb;
    logic             rd_tick;
    logic             run;
    logic             rd_bit;
    logic [PTR_W-1:0] fill;

    wr_strobe_sel #(.DIV_N(DIV_N)) u_sel (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
        .gate_pulse(gate_pulse), .wr_stb(wr_stb)
    );

    elastic_store #(.PTR_W(PTR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_stb), .wr_bit(gate_bit),
        .rd_en(rd_tick), .rd_bit(rd_bit), .fill(fill)
    );

    smooth_nco #(.ACC_W(ACC_W), .PTR_W(PTR_W), .STEP_NOM(STEP_NOM), .GAIN(GAIN)) u_nco (
        .clk(clk), .rst_n(rst_n), .run(run), .fill(fill), .rd_tick(rd_tick)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_PRIME;
            tstrobe <= 1'b0;
        end else begin
            state   <= state_nx;
            tstrobe <= rd_tick;
        end
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PRIME: if (fill >= MID) state_nx = ST_TRACK;                     // prime_done
            ST_TRACK: if (fill == '0 || fill == FULL) state_nx = ST_SLIP;       // slip
            ST_SLIP:  state_nx = ST_SLIP;
            default:  state_nx = ST_PRIME;
        endcase
        run       = (state != ST_PRIME);
        slip_err  = (state == ST_SLIP);
        dout      = rd_bit;
        dout_n    = ~rd_bit;
        tstrobe_n = ~tstrobe;
    end

    // R2: no read while priming
    assert_no_read_priming_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRIME) |-> !rd_tick);
    // R8: error flag is sticky
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slip_err |=> slip_err);
    // R3: timing strobe follows a read tick by one cycle
    assert_strobe_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_tick |=> tstrobe);
endmodule

// File: tb/test_rate_smoother.sv
module test_rate_smoother;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gate_pulse = 1'b0;
    logic gate_bit = 1'b0;
    logic rate_sel = 1'b0;
    logic dout, dout_n, tstrobe, tstrobe_n, slip_err;

    rate_smoother i_rate_smoother (
        .clk(clk), .rst_n(rst_n), .gate_pulse(gate_pulse), .gate_bit(gate_bit),
        .rate_sel(rate_sel), .dout(dout), .dout_n(dout_n), .tstrobe(tstrobe),
        .tstrobe_n(tstrobe_n), .slip_err(slip_err)
    );

    always #4 clk = ~clk;

    // {gap cycles after the pulse, data bit}; gaps average 8
    localparam logic [4:0] VEC [16] = '{
        {4'd8, 1'b1}, {4'd4, 1'b0}, {4'd12, 1'b1}, {4'd8, 1'b1},
        {4'd6, 1'b0}, {4'd10, 1'b0}, {4'd8, 1'b1}, {4'd8, 1'b0},
        {4'd4, 1'b1}, {4'd12, 1'b1}, {4'd7, 1'b0}, {4'd9, 1'b1},
        {4'd8, 1'b0}, {4'd8, 1'b0}, {4'd5, 1'b1}, {4'd11, 1'b0}
    };

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int last_rd = 0;
    bit expect_on = 0;
    bit lag_on = 0;
    bit smooth_on = 0;
    bit prev_ts = 0;
    bit done = 0;
    logic sent [256];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) cyc++;

    // read monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n && tstrobe) begin
            check(!prev_ts, "R3 single-cycle strobe", 1, 0);
            check(dout_n == ~dout && tstrobe_n == 1'b0, "R6 complements", int'(dout_n), int'(~dout));
            if (expect_on && rd_cnt < wr_cnt)
                check(dout == sent[rd_cnt], "R1/R3 bit order", int'(dout), int'(sent[rd_cnt]));
            if (lag_on)
                check((wr_cnt - rd_cnt) >= 3 && (wr_cnt - rd_cnt) <= 13, "R4 lag", wr_cnt - rd_cnt, 8);
            if (smooth_on && rd_cnt > 0)
                check((cyc - last_rd) >= 6 && (cyc - last_rd) <= 10, "R5 spacing", cyc - last_rd, 8);
            last_rd = cyc;
            rd_cnt++;
        end
        prev_ts = tstrobe;
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        gate_pulse = 1'b0;
        expect_on = 0; lag_on = 0; smooth_on = 0;
        repeat (4) @(negedge clk);
        wr_cnt = 0; rd_cnt = 0;
        check(dout == 0 && dout_n == 1 && tstrobe == 0 && tstrobe_n == 1 && slip_err == 0,
              "R9 reset state", {dout, dout_n, tstrobe, tstrobe_n, slip_err}, 5'b01010);
        rst_n = 1'b1;
        @(negedge clk);
        check(dout == 0 && dout_n == 1 && tstrobe == 0 && tstrobe_n == 1 && slip_err == 0,
              "R9 after reset", {dout, dout_n, tstrobe, tstrobe_n, slip_err}, 5'b01010);
    endtask

    // one gated pulse; record it as a write when 'accepted'
    task automatic pulse(input logic b, input int gap, input bit accepted);
        gate_pulse = 1'b1;
        gate_bit = b;
        if (accepted) begin
            sent[wr_cnt] = b;
            wr_cnt++;
        end
        @(negedge clk);
        gate_pulse = 1'b0;
        repeat (gap - 1) @(negedge clk);
    endtask

    function automatic logic div_bit(input int k);
        logic e;
        e = logic'(((k + 2) / 3) & 1);
        return (k % 3 == 0) ? e : ~e;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // table walk: bursty direct-mode stream (R1 R3 R4 R5 R6)
        rate_sel = 1'b0;
        do_reset();
        expect_on = 1;
        for (int i = 0; i < 64; i++) begin
            if (i == 16) begin lag_on = 1; smooth_on = 1; end
            pulse(VEC[i % 16][0], int'(VEC[i % 16][4:1]), 1);
        end
        lag_on = 0; smooth_on = 0;
        check(slip_err == 0, "R8 no error on nominal stream", int'(slip_err), 0);
        check(rd_cnt >= 48, "R3 reads delivered", rd_cnt, 48);
        // starve: fill drains to zero
        expect_on = 0;
        repeat (400) @(negedge clk);
        check(slip_err == 1, "R8 underflow sets error", int'(slip_err), 1);
        for (int i = 0; i < 16; i++) pulse(VEC[i][0], int'(VEC[i][4:1]), 1);
        check(slip_err == 1, "R8 error sticky", int'(slip_err), 1);

        // priming hold-off and overflow (R2 R8)
        do_reset();
        expect_on = 1;
        for (int i = 0; i < 7; i++) pulse(logic'(i & 1), 8, 1);
        repeat (100) @(negedge clk);
        check(rd_cnt == 0, "R2 no read before eight bits", rd_cnt, 0);
        pulse(1'b1, 20, 1);
        check(rd_cnt >= 1, "R2 reading starts", rd_cnt, 1);
        check(slip_err == 0, "R8 clear after priming", int'(slip_err), 0);
        expect_on = 0;
        for (int i = 0; i < 12; i++) pulse(1'b0, 1, 1);
        repeat (2) @(negedge clk);
        check(slip_err == 1, "R8 overflow sets error", int'(slip_err), 1);

        // divided write strobe (R7)
        @(negedge clk);
        rate_sel = 1'b1;
        do_reset();
        expect_on = 1;
        for (int k = 1; k <= 23; k++) pulse(div_bit(k), 2, k % 3 == 0);
        repeat (100) @(negedge clk);
        check(rd_cnt == 0, "R7 only 7 writes from 23 pulses", rd_cnt, 0);
        check(wr_cnt == 7, "R7 bench write count", wr_cnt, 7);
        for (int k = 24; k <= 60; k++) pulse(div_bit(k), 3, k % 3 == 0);
        check(rd_cnt >= 8, "R7 divided stream read out", rd_cnt, 8);
        check(slip_err == 0, "R7 divided stream no error", int'(slip_err), 0);
        expect_on = 0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule